// File: doc/BRIEF.md
# Quad SPI Instruction Frame Sequencer

This block is the host side of a serial flash command engine. Software, or a controller above it, loads a frame descriptor together with an instruction byte, a 24-bit address and an option byte. The engine then lowers chip select and clocks out the frame on up to four data lanes, using SPI clock mode 0. The frame can have an instruction phase, an address phase, an option phase, a run of dummy cycles and a data phase. Each phase is switched on or off on its own. One width code sets how many lanes each phase uses.

In the data phase, bytes to write are taken over a valid/ready byte port. Bytes read back are delivered one cycle at a time with a valid strobe. A frame with a data phase runs until the host pulses a last-transfer strobe. A frame with no data phase ends by itself. In both cases chip select rises and a sticky end-of-frame flag is set. The serial clock is the system clock divided by the parameter `SCK_DIV`, which must be even and at least 2.

Descriptor word layout (`desc_fmt`):
- bits 2:0: width code
- bit 4: instruction phase on
- bit 5: address phase on
- bit 6: option phase on
- bit 7: data phase on
- bit 13: direction (1 = write to flash, 0 = read)
- bits 23:16: dummy cycle count

Top module: `qfs_frame_seq`

## Requirements
- R1: After reset, `cs_n` is 1, `sck` is 0, `io_oe` is 0 and `eoi` is 0.
- R2: Clock mode 0. `sck` is low whenever `cs_n` is high and whenever the engine waits between data bytes. Driven lanes change only when `sck` falls. Input lanes are sampled when `sck` rises.
- R3: The phase order is fixed: instruction, address, option, dummy, data. A phase whose enable bit (4, 5, 6 or 7) is 0 is skipped and takes no `sck` cycles. The dummy phase is skipped when its count is 0.
- R4: Width code per phase, giving lanes for instruction/address/option/data:
  - 0: 1/1/1/1
  - 2: 1/1/1/4
  - 3: 1/2/2/2
  - 4: 1/4/4/4
  - 6: 4/4/4/4
  - other codes: as 0
  Driven lanes have their `io_oe` bits set: lane 0 for one lane, lanes 1:0 for two, lanes 3:0 for four.
- R5: The dummy phase lasts exactly as many `sck` cycles as `desc_fmt[23:16]`. During it, `io_oe` is 0.
- R6: A frame without a data phase ends once its last enabled phase is done, with no `last_xfer` needed.
- R7: In a write frame, each data byte is taken in a cycle where `tx_valid` and `tx_ready` are both high. While no byte is offered, `cs_n` stays low and `sck` stays low.
- R8: In a read frame, `io_oe` is 0 during data. The input is `io_in[1]` for one lane, `io_in[1:0]` for two lanes and `io_in[3:0]` for four lanes, with the first lane group as the most significant bits. Each byte is presented on `rx_data` with a one-cycle `rx_valid`.
- R9: `eoi` is set in the same cycle `cs_n` rises at the end of a frame. It stays set until the next descriptor write, which clears it on the following clock.
- R10: Fields go out most significant bit first: 8-bit instruction, 24-bit address, 8-bit option. With 2 or 4 lanes, the highest bit of each group is on the highest lane.
- R11: A `last_xfer` pulse during a data byte lets that byte finish. The frame then ends without starting another byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_we | input | 1 | Loads the descriptor and starts a frame (taken only while idle) |
| desc_fmt | input | 24 | Width code, phase enables, direction and dummy count |
| desc_inst | input | 8 | Instruction byte |
| desc_addr | input | 24 | Address |
| desc_opt | input | 8 | Option byte |
| tx_data | input | 8 | Byte to write |
| tx_valid | input | 1 | A write byte is offered |
| tx_ready | output | 1 | The offered byte is taken this cycle |
| rx_data | output | 8 | Last byte read |
| rx_valid | output | 1 | One-cycle strobe: `rx_data` holds a new byte |
| last_xfer | input | 1 | Ends the data phase after the current byte |
| eoi | output | 1 | Sticky end-of-frame flag |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |

## Verification
The bench models a flash device that logs lane values and enables on every rising `sck` edge. It checks each phase bit by bit, so a wrong lane order, a wrong bit order or a wrong beat count each show up in a different phase segment.

Frames cover:
- an instruction alone on one lane and on four lanes;
- instruction plus address;
- address plus option with the instruction skipped;
- a two-lane write with a stall between bytes;
- a four-lane read behind eight dummy cycles;
- an all-quad read with an option byte;
- a single-lane read.

The read data depends on the edge index, so a sample taken on the wrong edge or the wrong lane gives a different byte. The total edge count and the number of bytes received tell apart an early end, a missing end and an extra byte after `last_xfer`.

// File: rtl/qfs_pkg.sv
// Shared types and decode functions for the frame sequencer.
// Assumes phase enum order equals the fixed on-wire phase order.
package qfs_pkg;
    typedef enum logic [2:0] {PH_INST, PH_ADDR, PH_OPT, PH_DUMMY, PH_DATA, PH_END} phase_t;
    typedef enum logic [1:0] {S_IDLE, S_LAUNCH, S_SHIFT, S_DWAIT} state_t;
    typedef logic [1:0] lw_t;   // log2 of lanes in use

    // Lane count (log2) for one phase under a width code.
    function automatic lw_t lane_log2(input logic [2:0] wcode, input phase_t ph);
        lw_t r;
        r = 2'd0;
        case (ph)
            PH_INST: if (wcode == 3'd6) r = 2'd2;
            PH_ADDR, PH_OPT: begin
                if (wcode == 3'd3) r = 2'd1;
                else if (wcode == 3'd4 || wcode == 3'd6) r = 2'd2;
            end
            PH_DATA: begin
                if (wcode == 3'd3) r = 2'd1;
                else if (wcode == 3'd2 || wcode == 3'd4 || wcode == 3'd6) r = 2'd2;
            end
            default: r = 2'd0;
        endcase
        return r;
    endfunction

    // First enabled phase at or after index 'from'; en5 bit i enables phase i.
    function automatic phase_t pick_phase(input logic [2:0] from, input logic [4:0] en5);
        phase_t r;
        r = PH_END;
        for (int i = 4; i >= 0; i--)
            if (i >= int'(from) && en5[i]) r = phase_t'(3'(i));
        return r;
    endfunction

    // Serial bit length of a shifted field.
    function automatic int phase_bits(input phase_t ph);
        case (ph)
            PH_ADDR: return 24;
            PH_INST, PH_OPT, PH_DATA: return 8;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/qfs_sck.sv
// Serial clock generator: one SCK period is 2*HALF system clocks.
// While run is low the clock is parked low and the divider is cleared,
// so every beat starts with a full low half. rise/fall flag the cycle
// at whose end SCK goes high / low.
module qfs_sck #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck,
    output logic rise,
    output logic fall
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;
    logic          at_top;

    assign at_top = (cnt == CW'(HALF - 1));
    assign rise   = run && !sck && at_top;
    assign fall   = run && sck && at_top;

    // Divider counter and clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            sck <= 1'b0;
        end else if (at_top) begin
            cnt <= '0;
            sck <= ~sck;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_rise_gives_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> sck);
    assert_fall_gives_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !sck);
endmodule

// File: rtl/qfs_lanes.sv
// Lane shifter: a left-justified 32-bit transmit register whose top
// bits feed the lanes, and an 8-bit receive register filled on each
// sample strobe. Load has priority over shift.
module qfs_lanes
    import qfs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] load_val,
    input  logic        shift,
    input  logic        sample,
    input  lw_t         lw,
    input  logic [3:0]  io_in,
    output logic [3:0]  tx_lanes,
    output logic [7:0]  rx_byte
);
    logic [31:0] sr;

    // Transmit register: load a field or advance by one lane group.
    always_ff @(posedge clk) begin
        if (!rst_n)     sr <= '0;
        else if (load)  sr <= load_val;
        else if (shift) begin
            case (lw)
                2'd0:    sr <= {sr[30:0], 1'b0};
                2'd1:    sr <= {sr[29:0], 2'b0};
                default: sr <= {sr[27:0], 4'b0};
            endcase
        end
    end

    // Receive register: shift in one lane group per rising SCK.
    always_ff @(posedge clk) begin
        if (!rst_n)      rx_byte <= '0;
        else if (sample) begin
            case (lw)
                2'd0:    rx_byte <= {rx_byte[6:0], io_in[1]};
                2'd1:    rx_byte <= {rx_byte[5:0], io_in[1:0]};
                default: rx_byte <= {rx_byte[3:0], io_in};
            endcase
        end
    end

    // Highest pending bit lands on the highest lane in use.
    always_comb begin
        case (lw)
            2'd0:    tx_lanes = {3'b000, sr[31]};
            2'd1:    tx_lanes = {2'b00, sr[31:30]};
            default: tx_lanes = sr[31:28];
        endcase
    end

    assert_edges_apart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sample, shift}));
endmodule

// File: rtl/qfs_ctrl.sv
// Phase controller: walks the enabled phases in fixed order, counts
// beats per phase, runs the data byte loop until the last-transfer
// strobe, and owns chip select, lane enables and the end flag.
// Assumes fall pulses come from qfs_sck while run is high.
module qfs_ctrl
    import qfs_pkg::*;
#(
    parameter int DUMMY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               desc_we,
    input  logic [2:0]         fmt_width,
    input  logic [3:0]         fmt_en,      // {data, opt, addr, inst}
    input  logic               fmt_wr,
    input  logic [DUMMY_W-1:0] fmt_dummy,
    input  logic [7:0]         desc_inst,
    input  logic [23:0]        desc_addr,
    input  logic [7:0]         desc_opt,
    input  logic [7:0]         tx_data,
    input  logic               tx_valid,
    output logic               tx_ready,
    output logic               rx_valid,
    input  logic               last_xfer,
    input  logic               fall,
    output logic               run,
    output logic               load,
    output logic               shift,
    output logic [31:0]        load_val,
    output lw_t                lw,
    output logic               cs_n,
    output logic               eoi,
    output logic [3:0]         io_oe
);
    localparam int BW = (DUMMY_W > 5) ? DUMMY_W : 5;

    state_t             st;
    phase_t             ph, tgt;
    logic [BW-1:0]      beats;
    logic [2:0]         wcode;
    logic [4:0]         en5;
    logic               wr, last_pend;
    logic [7:0]         inst_q, opt_q;
    logic [23:0]        addr_q;
    logic [DUMMY_W-1:0] dcnt_q;
    logic               adv, enter, take;
    logic [2:0]         from;
    lw_t                tgt_lw;
    logic [3:0]         mask;

    // Next-phase selection and shifter load control.
    always_comb begin
        adv    = (st == S_SHIFT) && fall && (beats == BW'(1));
        from   = (st == S_LAUNCH) ? 3'd0 : 3'(ph) + 3'd1;
        tgt    = pick_phase(from, en5);
        enter  = (st == S_LAUNCH) || (adv && ph != PH_DATA);
        tgt_lw = lane_log2(wcode, tgt);
        take   = (st == S_DWAIT) && !last_pend && wr && tx_valid;
        load   = take || (enter && (tgt == PH_INST || tgt == PH_ADDR || tgt == PH_OPT));
        case (tgt)
            PH_INST: load_val = {inst_q, 24'h0};
            PH_ADDR: load_val = {addr_q, 8'h0};
            PH_OPT:  load_val = {opt_q, 24'h0};
            default: load_val = {tx_data, 24'h0};
        endcase
    end

    assign tx_ready = take;
    assign shift    = fall;
    assign run      = (st == S_SHIFT);
    assign rx_valid = adv && (ph == PH_DATA) && !wr;

    // Lane enables: driven phases only, never dummy or read data.
    always_comb begin
        case (lw)
            2'd0:    mask = 4'b0001;
            2'd1:    mask = 4'b0011;
            default: mask = 4'b1111;
        endcase
        io_oe = 4'b0000;
        if (st == S_SHIFT &&
            (ph == PH_INST || ph == PH_ADDR || ph == PH_OPT || (ph == PH_DATA && wr)))
            io_oe = mask;
    end

    // Frame state, beat count, phase entry and end-of-frame handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE;  ph <= PH_END;  beats <= '0;  lw <= 2'd0;
            cs_n <= 1'b1;  eoi <= 1'b0;   last_pend <= 1'b0;
            wcode <= '0;   en5 <= '0;     wr <= 1'b0;
            inst_q <= '0;  addr_q <= '0;  opt_q <= '0;  dcnt_q <= '0;
        end else begin
            if (st != S_IDLE && last_xfer) last_pend <= 1'b1;
            case (st)
                S_IDLE: if (desc_we) begin
                    wcode <= fmt_width;
                    en5 <= {fmt_en[3], fmt_dummy != '0, fmt_en[2:0]};
                    wr <= fmt_wr;  dcnt_q <= fmt_dummy;
                    inst_q <= desc_inst;  addr_q <= desc_addr;  opt_q <= desc_opt;
                    eoi <= 1'b0;  cs_n <= 1'b0;  last_pend <= 1'b0;
                    st <= S_LAUNCH;
                end
                S_SHIFT: if (fall) begin
                    if (beats != BW'(1))  beats <= beats - 1'b1;
                    else if (ph == PH_DATA) st <= S_DWAIT;
                end
                S_DWAIT: begin
                    if (last_pend) begin
                        st <= S_IDLE;  cs_n <= 1'b1;  eoi <= 1'b1;  ph <= PH_END;
                    end else if (!wr || tx_valid) begin
                        st <= S_SHIFT;
                        beats <= BW'(8 >> lw);
                    end
                end
                default: ;
            endcase
            if (enter) begin
                ph <= tgt;
                lw <= tgt_lw;
                case (tgt)
                    PH_DATA:  st <= S_DWAIT;
                    PH_END:   begin st <= S_IDLE; cs_n <= 1'b1; eoi <= 1'b1; end
                    PH_DUMMY: begin st <= S_SHIFT; beats <= BW'(dcnt_q); end
                    default:  begin st <= S_SHIFT; beats <= BW'(phase_bits(tgt) >> tgt_lw); end
                endcase
            end
        end
    end

    assert_dummy_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SHIFT && ph == PH_DUMMY) |-> (io_oe == 4'b0000));
    assert_read_only_in_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (!wr && io_oe == 4'b0000));
    assert_eoi_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !desc_we) |=> eoi);
    assert_take_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !cs_n);
endmodule

// File: rtl/qfs_frame_seq.sv
// Top of the frame sequencer: splits the descriptor word, and joins
// the clock divider, lane shifter and phase controller.
// Assumes SCK_DIV is even and at least 2.
module qfs_frame_seq
    import qfs_pkg::*;
#(
    parameter int SCK_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        desc_we,
    input  logic [23:0] desc_fmt,
    input  logic [7:0]  desc_inst,
    input  logic [23:0] desc_addr,
    input  logic [7:0]  desc_opt,
    input  logic [7:0]  tx_data,
    input  logic        tx_valid,
    output logic        tx_ready,
    output logic [7:0]  rx_data,
    output logic        rx_valid,
    input  logic        last_xfer,
    output logic        eoi,
    output logic        sck,
    output logic        cs_n,
    output logic [3:0]  io_out,
    output logic [3:0]  io_oe,
    input  logic [3:0]  io_in
);
    localparam int HALF    = SCK_DIV / 2;
    localparam int DUMMY_W = 8;

    logic        run, rise, fall, load, shift;
    logic [31:0] load_val;
    lw_t         lw;
    logic        fmt_unused;

    assign fmt_unused = ^{desc_fmt[3], desc_fmt[12:8], desc_fmt[15:14]};

    qfs_sck #(.HALF(HALF)) u_sck (
        .clk(clk), .rst_n(rst_n), .run(run), .sck(sck), .rise(rise), .fall(fall)
    );

    qfs_lanes u_lanes (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .shift(shift),
        .sample(rise), .lw(lw), .io_in(io_in), .tx_lanes(io_out), .rx_byte(rx_data)
    );

    qfs_ctrl #(.DUMMY_W(DUMMY_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .desc_we(desc_we),
        .fmt_width(desc_fmt[2:0]), .fmt_en(desc_fmt[7:4]), .fmt_wr(desc_fmt[13]),
        .fmt_dummy(desc_fmt[23:16]),
        .desc_inst(desc_inst), .desc_addr(desc_addr), .desc_opt(desc_opt),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .last_xfer(last_xfer), .fall(fall),
        .run(run), .load(load), .shift(shift), .load_val(load_val), .lw(lw),
        .cs_n(cs_n), .eoi(eoi), .io_oe(io_oe)
    );

    assert_clock_parked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);
    assert_eoi_with_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoi) |-> cs_n);
endmodule

// File: tb/sim_qfs_frame_seq.sv
// Directed bench: a flash model logs lanes on each rising SCK and
// drives io_in from the edge index; each task checks its own frame.
module sim_qfs_frame_seq;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        desc_we = 1'b0, tx_valid = 1'b0, last_xfer = 1'b0;
    logic [23:0] desc_fmt = '0, desc_addr = '0;
    logic [7:0]  desc_inst = '0, desc_opt = '0, tx_data = '0;
    logic        tx_ready, rx_valid, eoi, sck, cs_n;
    logic [7:0]  rx_data;
    logic [3:0]  io_out, io_oe, io_in;

    int          checks = 0, errors = 0;
    logic        clr_log = 1'b0;
    int          edge_cnt = 0, rx_n = 0;
    logic [3:0]  log_out [0:127];
    logic [3:0]  log_oe  [0:127];
    logic [7:0]  rx_buf  [0:7];

    always #5 clk = ~clk;

    qfs_frame_seq u0 (
        .clk(clk), .rst_n(rst_n), .desc_we(desc_we), .desc_fmt(desc_fmt),
        .desc_inst(desc_inst), .desc_addr(desc_addr), .desc_opt(desc_opt),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .last_xfer(last_xfer),
        .eoi(eoi), .sck(sck), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
    );

    function automatic logic [3:0] fpat(input int n);
        return 4'((n * 7 + 5) & 15);
    endfunction

    // Flash model: log lanes on rising SCK.
    always @(posedge sck or posedge clr_log) begin
        if (clr_log) edge_cnt <= 0;
        else begin
            if (edge_cnt < 128) begin
                log_out[edge_cnt] <= io_out;
                log_oe[edge_cnt]  <= io_oe;
            end
            edge_cnt <= edge_cnt + 1;
        end
    end

    // Flash model: present the next input nibble after falling SCK.
    always @(negedge sck or posedge clr_log)
        io_in <= clr_log ? fpat(0) : fpat(edge_cnt);

    // Collect read bytes.
    always @(posedge clk) begin
        if (clr_log) rx_n <= 0;
        else if (rx_valid) begin
            if (rx_n < 8) rx_buf[rx_n] <= rx_data;
            rx_n <= rx_n + 1;
        end
    end

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Compare one shifted field against the log, starting at edge s.
    task automatic chk_seg(input string rq, input int s, input logic [31:0] val, input int nbits, input int lg);
        int L = 1 << lg;
        int bad = 0;
        logic [3:0] mask = (lg == 0) ? 4'b0001 : (lg == 1) ? 4'b0011 : 4'b1111;
        for (int b = 0; b < nbits / L; b++) begin
            logic [3:0] ex;
            ex = 4'b0;
            for (int k = 0; k < L; k++) ex[k] = val[nbits - 1 - b * L - (L - 1 - k)];
            if (((log_out[s + b] & mask) != ex) || (log_oe[s + b] != mask)) bad++;
        end
        check(bad == 0, rq, bad, 0);
    endtask

    task automatic chk_oe_off(input string rq, input int s, input int n);
        int bad = 0;
        for (int e = s; e < s + n; e++) if (log_oe[e] != 4'b0) bad++;
        check(bad == 0, rq, bad, 0);
    endtask

    function automatic logic [7:0] exp_rx(input int s, input int lg);
        logic [7:0] b;
        b = 8'h0;
        for (int e = 0; e < (8 >> lg); e++) begin
            logic [3:0] n;
            n = fpat(s + e);
            case (lg)
                0:       b = {b[6:0], n[1]};
                1:       b = {b[5:0], n[1:0]};
                default: b = {b[3:0], n};
            endcase
        end
        return b;
    endfunction

    task automatic launch(input logic [23:0] fmt, input logic [7:0] ic, input logic [23:0] ad, input logic [7:0] op);
        @(negedge clk);
        clr_log = 1'b1; desc_fmt = fmt; desc_inst = ic; desc_addr = ad; desc_opt = op; desc_we = 1'b1;
        @(negedge clk);
        clr_log = 1'b0; desc_we = 1'b0;
    endtask

    task automatic wait_eoi(input string rq);
        int n = 0;
        while (!eoi && n < 5000) begin @(negedge clk); n++; end
        check(eoi == 1'b1, rq, eoi, 1);
    endtask

    task automatic send_tx(input logic [7:0] d);
        @(negedge clk);
        tx_data = d; tx_valid = 1'b1;
        #1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic pulse_last;
        @(negedge clk); last_xfer = 1'b1;
        @(negedge clk); last_xfer = 1'b0;
    endtask

    task automatic wait_rx(input int cnt);
        int n = 0;
        while (rx_n < cnt && n < 5000) begin @(negedge clk); n++; end
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
        check(sck == 1'b0, "R1 sck", sck, 0);
        check(io_oe == 4'b0, "R1 io_oe", io_oe, 0);
        check(eoi == 1'b0, "R1 eoi", eoi, 0);
    endtask

    task automatic t_inst_single;
        launch(24'h000010, 8'hC7, 24'h0, 8'h0);
        wait_eoi("R6 inst-only end");
        @(negedge clk);
        check(edge_cnt == 8, "R3 inst-only edge count", edge_cnt, 8);
        chk_seg("R10 inst single lane", 0, 32'hC7, 8, 0);
        check(cs_n == 1'b1 && sck == 1'b0, "R2 idle after frame", {cs_n, sck}, 2'b10);
    endtask

    task automatic t_inst_quad;
        launch(24'h000016, 8'hB9, 24'h0, 8'h0);
        check(eoi == 1'b0, "R9 eoi cleared by new descriptor", eoi, 0);
        wait_eoi("R9 eoi set");
        repeat (20) @(negedge clk);
        check(eoi == 1'b1, "R9 eoi sticky", eoi, 1);
        check(edge_cnt == 2, "R4 quad inst edge count", edge_cnt, 2);
        chk_seg("R4 quad inst lanes", 0, 32'hB9, 8, 2);
    endtask

    task automatic t_inst_addr;
        launch(24'h000030, 8'h20, 24'hA5C31E, 8'h0);
        wait_eoi("R6 inst+addr end");
        @(negedge clk);
        check(edge_cnt == 32, "R3 inst+addr edge count", edge_cnt, 32);
        chk_seg("R10 inst", 0, 32'h20, 8, 0);
        chk_seg("R10 addr single", 8, 32'hA5C31E, 24, 0);
    endtask

    task automatic t_addr_opt_quad;
        launch(24'h000064, 8'hFF, 24'h9B0F61, 8'h5C);
        wait_eoi("R6 addr+opt end");
        @(negedge clk);
        check(edge_cnt == 8, "R3 inst skipped edge count", edge_cnt, 8);
        chk_seg("R3 addr first when inst off", 0, 32'h9B0F61, 24, 2);
        chk_seg("R4 opt quad", 6, 32'h5C, 8, 2);
    endtask

    task automatic t_write_dual;
        launch(24'h0020B3, 8'h02, 24'h3C5A96, 8'h0);
        send_tx(8'hA7);
        repeat (200) @(negedge clk);
        check(cs_n == 1'b0 && sck == 1'b0, "R7 stall holds cs low, sck low", {cs_n, sck}, 2'b00);
        check(edge_cnt == 24, "R7 stall edge count", edge_cnt, 24);
        send_tx(8'h1E);
        send_tx(8'hD4);
        pulse_last();
        wait_eoi("R11 write end after last");
        @(negedge clk);
        check(edge_cnt == 32, "R11 write edge count", edge_cnt, 32);
        chk_seg("R4 inst single in code 3", 0, 32'h02, 8, 0);
        chk_seg("R10 addr dual", 8, 32'h3C5A96, 24, 1);
        chk_seg("R7 data byte 0", 20, 32'hA7, 8, 1);
        chk_seg("R7 data byte 1", 24, 32'h1E, 8, 1);
        chk_seg("R7 data byte 2", 28, 32'hD4, 8, 1);
    endtask

    task automatic t_read_quad_dummy;
        launch(24'h0800B2, 8'h6B, 24'h01F2E3, 8'h0);
        wait_rx(1);
        pulse_last();
        wait_eoi("R11 read end");
        @(negedge clk);
        check(edge_cnt == 44, "R5 dummy 8 edge count", edge_cnt, 44);
        check(rx_n == 2, "R11 byte count after last", rx_n, 2);
        chk_seg("R10 addr single", 8, 32'h01F2E3, 24, 0);
        chk_oe_off("R5 dummy lanes released", 32, 8);
        chk_oe_off("R8 read data not driven", 40, 4);
        check(rx_buf[0] == exp_rx(40, 2), "R8 quad byte 0", rx_buf[0], exp_rx(40, 2));
        check(rx_buf[1] == exp_rx(42, 2), "R8 quad byte 1", rx_buf[1], exp_rx(42, 2));
    endtask

    task automatic t_read_all_quad;
        launch(24'h0200F6, 8'hEB, 24'h123456, 8'h30);
        wait_rx(1);
        pulse_last();
        wait_eoi("R11 quad read end");
        @(negedge clk);
        check(edge_cnt == 16, "R5 dummy 2 edge count", edge_cnt, 16);
        chk_seg("R4 inst quad", 0, 32'hEB, 8, 2);
        chk_seg("R4 addr quad", 2, 32'h123456, 24, 2);
        chk_seg("R3 opt after addr", 8, 32'h30, 8, 2);
        chk_oe_off("R5 dummy released", 10, 2);
        check(rx_buf[0] == exp_rx(12, 2), "R8 byte 0", rx_buf[0], exp_rx(12, 2));
        check(rx_buf[1] == exp_rx(14, 2), "R8 byte 1", rx_buf[1], exp_rx(14, 2));
    endtask

    task automatic t_read_single;
        launch(24'h000090, 8'h05, 24'h0, 8'h0);
        wait_rx(1);
        pulse_last();
        wait_eoi("R11 single read end");
        @(negedge clk);
        check(edge_cnt == 24, "R3 inst+data edge count", edge_cnt, 24);
        check(rx_n == 2, "R11 single read bytes", rx_n, 2);
        check(rx_buf[0] == exp_rx(8, 0), "R8 single lane byte 0", rx_buf[0], exp_rx(8, 0));
        check(rx_buf[1] == exp_rx(16, 0), "R8 single lane byte 1", rx_buf[1], exp_rx(16, 0));
    endtask

    initial begin
        #1500000;
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_inst_single();
        t_inst_quad();
        t_inst_addr();
        t_addr_opt_quad();
        t_write_dual();
        t_read_quad_dummy();
        t_read_all_quad();
        t_read_single();
        repeat (5) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule